// File: doc/BRIEF.md
# Flash Power-Mode and Reset Front End

This block sits in front of the command logic of a parallel NOR flash behavioural model. It samples the active-low chip enable, output enable, write enable and hardware reset pins together with the address bus. From these it settles on one of four power modes: active, standby, automatic sleep or reset. It then drives the enable of the data-bus tristate and a registered copy of the word to put on the bus. It also drives a ready flag and raises a one-cycle abort strobe that sends the command state machine back to array-read.

Every timing figure is counted in clock cycles and set by a parameter: the address access time, the extra quiet time before sleep, the chip-enable access time and the minimum reset pulse width. A busy input stands in for the embedded program/erase engine. The array data arrive on a plain input bus.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: Mode codes on `mode_o` are 0 active, 1 standby, 2 sleep, 3 reset. With `ce_n` high, `hw_rst_n` high and no operation running, the mode is 1 from the next clock edge. In standby `dq_oe` is 0 whatever `oe_n` does. While `rst_n` is low, the outputs read mode 0, `dq_oe` 0, `data_valid` 0, `rdy_o` 1 and `abort_o` 0.
- R2: An operation starts on a rising `busy_i` and holds `rdy_o` low. While it runs, a high `ce_n` keeps mode 0. At the edge where `busy_i` is seen low, the operation ends, `rdy_o` returns to 1 and, if `ce_n` is high, the mode becomes 1.
- R3: Count from the edge that samples a new address. After T_ACC_CYC+T_EXTRA_CYC further edges with the address unchanged, `ce_n` low and no operation running, the mode becomes 2. The edge that samples a different address returns the mode to 0.
- R4: While in sleep, toggling `oe_n` or `we_n` does not leave mode 2.
- R5: During sleep, `dq_o` keeps the last word captured in active mode even when `rd_data_i` changes. `dq_oe` still follows `oe_n`.
- R6: Once `hw_rst_n` has been sampled low on RST_MIN_CYC consecutive edges, the mode is 3 from that edge until the first edge that samples it high. In that mode `dq_oe` and `data_valid` are 0.
- R7: A valid reset pulses `abort_o` high for exactly one cycle, at the edge where the low count reaches RST_MIN_CYC. It also cancels the running operation (`rdy_o` 1), which stays cancelled after release until a new rising `busy_i`.
- R8: `oe_n` high drives `dq_oe` to 0 in every mode, while `rdy_o` keeps reporting the operation status.
- R9: A `hw_rst_n` low pulse shorter than RST_MIN_CYC edges gives no abort, leaves the mode and outputs unchanged and does not cancel a running operation.
- R10: `data_valid` rises only at the T_CE_CYC-th consecutive edge that samples `ce_n` low, counted afresh after a valid reset.
- R11: After a new address is sampled, `data_valid` is 0 until T_ACC_CYC further edges have passed. Until then `dq_o` holds the previous word, and it carries the new word once valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous-domain system reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, width-filtered |
| addr | input | AW | Address bus |
| busy_i | input | 1 | Embedded program/erase engine busy (stub) |
| rd_data_i | input | DW | Array read data |
| dq_o | output | DW | Registered word for the data bus |
| dq_oe | output | 1 | Data-bus tristate enable |
| data_valid | output | 1 | Read data meets access timing |
| rdy_o | output | 1 | Ready (1) / busy (0) flag, always driven |
| abort_o | output | 1 | One-cycle abort strobe to the command state machine |
| mode_o | output | 2 | Power mode code |

## Verification
Two functions can fall in the same cycle. A hardware reset can reach its minimum width while an embedded operation is holding the block active with chip enable high. The bench starts an operation, deselects the device and sweeps reset pulses of every width up to and past the minimum. Each pulse width is judged edge by edge: the mode, the abort strobe and the ready flag must follow the pulse length alone. A second overlap is the address quiet counter running out at the same point the chip-enable access time expires. The bench sweeps both after a single combined event and checks in which cycle valid data and sleep appear.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
    typedef enum logic [1:0] {
        M_ACTIVE = 2'd0,
        M_STBY   = 2'd1,
        M_SLEEP  = 2'd2,
        M_RESET  = 2'd3
    } pmode_e;
endpackage

// File: rtl/flash_pwr_satcnt.sv
module flash_pwr_satcnt #(
    parameter int MAX = 4,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt_next,
    output logic         full_next
);
    localparam logic [W-1:0] TOP = W'(MAX);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)               cnt_d = '0;
        else if (cnt_q == TOP) cnt_d = TOP;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next  = cnt_d;
    assign full_next = (cnt_d == TOP);

    // R10: count never passes its limit
    a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/flash_pwr_addr_watch.sv
module flash_pwr_addr_watch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic          changed
);
    logic [AW-1:0] prev_d, prev_q;

    always_comb prev_d = addr;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign changed = (addr != prev_q);
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import flash_pwr_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int T_ACC_CYC   = 4,
    parameter int T_EXTRA_CYC = 3,
    parameter int T_CE_CYC    = 5,
    parameter int RST_MIN_CYC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hw_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          data_valid,
    output logic          rdy_o,
    output logic          abort_o,
    output logic [1:0]    mode_o
);
    localparam int SLEEP_CYC = T_ACC_CYC + T_EXTRA_CYC;
    localparam int ST_W      = $clog2(SLEEP_CYC + 1);
    localparam int CE_W      = $clog2(T_CE_CYC + 1);
    localparam int RS_W      = $clog2(RST_MIN_CYC + 1);

    typedef struct packed {
        pmode_e        mode;
        logic          op;
        logic          busy_prev;
        logic          rst_full;
        logic          abort;
        logic          oe;
        logic          valid;
        logic [DW-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic            addr_chg;
    logic [ST_W-1:0] quiet_cnt;
    logic            quiet_full;
    logic [CE_W-1:0] ce_cnt;
    logic            ce_full;
    logic [RS_W-1:0] rs_cnt;
    logic            rs_full;

    flash_pwr_addr_watch #(.AW(AW)) u_watch (
        .clk(clk), .rst_n(rst_n), .addr(addr), .changed(addr_chg)
    );

    flash_pwr_satcnt #(.MAX(SLEEP_CYC), .W(ST_W)) u_quiet (
        .clk(clk), .rst_n(rst_n), .clr(addr_chg),
        .cnt_next(quiet_cnt), .full_next(quiet_full)
    );

    flash_pwr_satcnt #(.MAX(RST_MIN_CYC), .W(RS_W)) u_rstw (
        .clk(clk), .rst_n(rst_n), .clr(hw_rst_n),
        .cnt_next(rs_cnt), .full_next(rs_full)
    );

    flash_pwr_satcnt #(.MAX(T_CE_CYC), .W(CE_W)) u_ceacc (
        .clk(clk), .rst_n(rst_n), .clr(ce_n | rs_full),
        .cnt_next(ce_cnt), .full_next(ce_full)
    );

    always_comb begin
        st_d           = st_q;
        st_d.abort     = 1'b0;
        st_d.busy_prev = busy_i;
        st_d.rst_full  = rs_full;
        st_d.op        = !rs_full && busy_i && (st_q.op || !st_q.busy_prev);
        if (rs_full) begin
            st_d.mode  = M_RESET;
            st_d.oe    = 1'b0;
            st_d.valid = 1'b0;
            st_d.abort = !st_q.rst_full;
        end else if (hw_rst_n) begin
            if (ce_n && !st_d.op)            st_d.mode = M_STBY;
            else if (quiet_full && !st_d.op) st_d.mode = M_SLEEP;
            else                             st_d.mode = M_ACTIVE;
            st_d.valid = (st_d.mode != M_STBY) && ce_full
                         && (quiet_cnt >= ST_W'(T_ACC_CYC));
            st_d.oe    = (st_d.mode != M_STBY) && !oe_n && !ce_n && we_n;
            if (st_d.mode == M_ACTIVE && st_d.valid) st_d.data = rd_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= M_ACTIVE;
            st_q.op        <= 1'b0;
            st_q.busy_prev <= 1'b0;
            st_q.rst_full  <= 1'b0;
            st_q.abort     <= 1'b0;
            st_q.oe        <= 1'b0;
            st_q.valid     <= 1'b0;
            st_q.data      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o       = st_q.data;
    assign dq_oe      = st_q.oe;
    assign data_valid = st_q.valid;
    assign rdy_o      = !st_q.op;
    assign abort_o    = st_q.abort;
    assign mode_o     = st_q.mode;

    // R6: reset mode keeps the bus released and data invalid
    a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RESET) |-> (!st_q.oe && !st_q.valid && !st_q.op));
    // R7: abort lasts one cycle
    a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |=> !st_q.abort);
    // R7: abort only alongside reset mode
    a_r7_abort_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |-> (st_q.mode == M_RESET));
    // R1: standby means idle engine and released bus
    a_r1_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_STBY) |-> (!st_q.op && !st_q.oe));
    // R3: sleep only after an unchanged address sample
    a_r3_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SLEEP) |-> ($past(addr) == $past(addr, 2)));
    // R8: bus enable needs output enable low when pin sampled
    a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oe && $past(hw_rst_n)) |-> !$past(oe_n));
endmodule

// File: tb/tb_flash_pwr_ctrl.sv
module tb_flash_pwr_ctrl;
    localparam int CLK_P   = 10;
    localparam int AW      = 8;
    localparam int DW      = 16;
    localparam int T_ACC   = 4;
    localparam int T_EXTRA = 3;
    localparam int T_CE    = 5;
    localparam int RST_MIN = 6;
    localparam int SLEEP   = T_ACC + T_EXTRA;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, oe_n, we_n, hw_rst_n, busy_i;
    logic [AW-1:0] addr;
    logic [DW-1:0] rd_xor, rd_data;
    logic [DW-1:0] dq_o;
    logic          dq_oe, data_valid, rdy_o, abort_o;
    logic [1:0]    mode_o;
    int nvec = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return DW'(32'(a) * 7 + 32'h0A05);
    endfunction

    assign rd_data = fdata(addr) ^ rd_xor;

    flash_pwr_ctrl #(.AW(AW), .DW(DW), .T_ACC_CYC(T_ACC), .T_EXTRA_CYC(T_EXTRA),
                     .T_CE_CYC(T_CE), .RST_MIN_CYC(RST_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_rst_n(hw_rst_n), .addr(addr), .busy_i(busy_i), .rd_data_i(rd_data),
        .dq_o(dq_o), .dq_oe(dq_oe), .data_valid(data_valid), .rdy_o(rdy_o),
        .abort_o(abort_o), .mode_o(mode_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [AW-1:0] prev;
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; hw_rst_n = 1;
        addr = '0; busy_i = 0; rd_xor = '0;
        repeat (3) step();
        // R1 reset state
        chk("R1 rst mode", 32'(mode_o), 0);
        chk("R1 rst oe", 32'(dq_oe), 0);
        chk("R1 rst valid", 32'(data_valid), 0);
        chk("R1 rst rdy", 32'(rdy_o), 1);
        chk("R1 rst abort", 32'(abort_o), 0);
        rst_n = 1;
        step();
        chk("R1 standby", 32'(mode_o), 1);
        oe_n = 0;
        step();
        chk("R1 standby oe", 32'(dq_oe), 0);
        chk("R1 standby hold", 32'(mode_o), 1);

        // R10 / R3: chip enable and new address together
        addr = 8'h11; ce_n = 0;
        for (int k = 1; k <= SLEEP + 2; k++) begin
            step();
            chk("R10 valid", 32'(data_valid), 32'((k >= T_CE) && (k - 1 >= T_ACC)));
            chk("R3 mode", 32'(mode_o), (k - 1 >= SLEEP) ? 2 : 0);
            chk("R8 oe low drives", 32'(dq_oe), 1);
            if (k >= T_CE) chk("R11 data", 32'(dq_o), 32'(fdata(8'h11)));
        end

        // R5 / R4 / R8 in sleep
        rd_xor = 16'hFFFF;
        step();
        chk("R5 held word", 32'(dq_o), 32'(fdata(8'h11)));
        chk("R5 mode", 32'(mode_o), 2);
        oe_n = 1; we_n = 0;
        step();
        chk("R4 sleep ctl", 32'(mode_o), 2);
        chk("R8 oe high", 32'(dq_oe), 0);
        we_n = 1; oe_n = 0;
        step();
        chk("R4 sleep ctl2", 32'(mode_o), 2);
        chk("R5 oe follows", 32'(dq_oe), 1);
        chk("R5 held word2", 32'(dq_o), 32'(fdata(8'h11)));
        rd_xor = '0;

        // R11 / R3 sweeps over fresh addresses
        prev = 8'h11;
        for (int n = 0; n < 4; n++) begin
            addr = AW'(8'h20 + n);
            for (int k = 1; k <= SLEEP + 1; k++) begin
                step();
                chk("R3 sweep mode", 32'(mode_o), (k - 1 >= SLEEP) ? 2 : 0);
                chk("R11 valid", 32'(data_valid), 32'(k - 1 >= T_ACC));
                if (k == 1) chk("R11 old word", 32'(dq_o), 32'(fdata(prev)));
                if (k == T_ACC + 1) chk("R11 new word", 32'(dq_o), 32'(fdata(addr)));
            end
            prev = addr;
        end

        // R2: deselect during operation
        busy_i = 1;
        step();
        chk("R2 busy", 32'(rdy_o), 0);
        ce_n = 1;
        for (int k = 1; k <= SLEEP + 3; k++) begin
            step();
            chk("R2 stays active", 32'(mode_o), 0);
            chk("R2 rdy low", 32'(rdy_o), 0);
        end

        // R9: short reset pulses during the operation
        for (int w = 1; w < RST_MIN; w++) begin
            hw_rst_n = 0;
            for (int k = 1; k <= w; k++) begin
                step();
                chk("R9 no abort", 32'(abort_o), 0);
                chk("R9 mode kept", 32'(mode_o), 0);
                chk("R9 op kept", 32'(rdy_o), 0);
            end
            hw_rst_n = 1;
            step();
            chk("R9 after pulse", 32'(rdy_o), 0);
            chk("R9 after mode", 32'(mode_o), 0);
        end

        // R6 / R7: valid reset during the operation
        hw_rst_n = 0;
        for (int k = 1; k <= RST_MIN + 2; k++) begin
            step();
            chk("R7 abort", 32'(abort_o), 32'(k == RST_MIN));
            chk("R6 mode", 32'(mode_o), (k >= RST_MIN) ? 3 : 0);
            chk("R7 op cancel", 32'(rdy_o), 32'(k >= RST_MIN));
            chk("R6 oe", 32'(dq_oe), 0);
        end
        hw_rst_n = 1; ce_n = 0; addr = 8'h40;
        for (int k = 1; k <= T_CE + 1; k++) begin
            step();
            chk("R6 release mode", 32'(mode_o), 0);
            chk("R7 stays cancelled", 32'(rdy_o), 1);
            chk("R10 after reset", 32'(data_valid), 32'(k >= T_CE));
        end

        // R2: operation end while deselected
        busy_i = 0;
        step();
        busy_i = 1;
        step();
        chk("R2 restart", 32'(rdy_o), 0);
        ce_n = 1;
        step();
        chk("R2 active while busy", 32'(mode_o), 0);
        busy_i = 0;
        step();
        chk("R2 standby after op", 32'(mode_o), 1);
        chk("R2 ready", 32'(rdy_o), 1);
        chk("R1 standby bus", 32'(dq_oe), 0);

        finish_run();
    end
endmodule